// File: doc/BRIEF.md
# ECC Error Capture and Status Controller

This block is a register-mapped controller placed next to one ECC-protected memory. Software uses a small 32-bit register window to switch error correction on and to set an 8-bit mask. The memory's encode/decode path uses that mask to flip syndrome bits on purpose, so that single-bit and double-bit errors can be injected during test.

The memory-side decoder sends a pulse for each single-bit error (SBE) and each double-bit error (DBE), together with the 15-bit word address of the access. For each error class the block keeps a sticky status flag. It also keeps the address of the first error of that class. That address stays frozen until software clears the flag by writing a one to it. An interrupt line is high while either flag is set.

Top module: `ecc_err_monitor`

## Requirements
- R1: The registers sit at byte offsets 0x00 (control), 0x04 (SBE address), 0x08 (DBE address), 0x0C (SBE status) and 0x10 (DBE status). Any other offset reads zero, and a write to it changes nothing.
- R2: The control register holds the enable in bit 0, which drives `ecc_en`, and the syndrome flip mask in bits 8..1, which drives `syn_flip`. Bits 31..9 read zero.
- R3: The SBE and DBE address registers are read-only. Each returns its captured address in bits 14..0, and bits 31..15 read zero.
- R4: The address of an SBE is captured only while the SBE status bit is clear. Later SBEs leave it unchanged while the bit stays set.
- R5: The address of a DBE is captured only while the DBE status bit is clear. Later DBEs leave it unchanged while the bit stays set.
- R6: Bit 0 of each status register is set by an error of its class. Writing 1 to that bit clears it, and writing 0 leaves it unchanged. Bits 31..1 read zero.
- R7: `irq` is high exactly when the SBE status bit or the DBE status bit is set.
- R8: If an error and a write-1-to-clear of the same class fall in one cycle, the status bit ends up set. The address is captured only if the bit was clear before that cycle.
- R9: While the enable bit is 0, error pulses change neither status nor address.
- R10: An SBE and a DBE in the same cycle each update their own status and address.
- R11: After reset every register reads zero, and `ecc_en`, `syn_flip` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| ev_single | input | 1 | Single-bit error pulse from the decoder |
| ev_double | input | 1 | Double-bit error pulse from the decoder |
| ev_addr | input | 15 | Word address of the access that reported the error |
| ecc_en | output | 1 | ECC enable to the memory path |
| syn_flip | output | 8 | Syndrome inversion mask for error injection |
| irq | output | 1 | Interrupt, high while either status bit is set |

## Verification
The in-RTL assertions check, on every cycle, four things for each class: a frozen address stays stable while its flag is set, an enabled error always sets the flag, the first address is captured exactly, and a disabled error leaves a clear flag clear. They also check that a rising interrupt always follows an enabled error pulse. The bench's scenarios are needed to show the rest:
- the register decode, including unmapped offsets and the zero upper bits;
- that writes to the read-only addresses are ignored;
- that a write of 0 does not clear a flag;
- the priority of a same-cycle set and clear;
- the independence of simultaneous SBE and DBE events over long random sequences.

// File: rtl/ecc_mon_pkg.sv
// Package: shared constants for the ECC error monitor.
// Assumes byte offsets that fit in the register address width of the top.
package ecc_mon_pkg;
    localparam int unsigned OFS_CTRL     = 'h00;
    localparam int unsigned OFS_SBE_ADDR = 'h04;
    localparam int unsigned OFS_DBE_ADDR = 'h08;
    localparam int unsigned OFS_SBE_STAT = 'h0C;
    localparam int unsigned OFS_DBE_STAT = 'h10;
    localparam int unsigned NUM_CLASSES  = 2;   // index 0 = single, 1 = double
endpackage

// File: rtl/ecc_mon_ctrl_reg.sv
// Module: control register holding the ECC enable and the syndrome flip mask.
// Assumes wr_i is already qualified with the control-register decode.
module ecc_mon_ctrl_reg #(
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [MASK_W:0]   wdata_i,
    output logic              en_o,
    output logic [MASK_W-1:0] mask_o
);
    // Load enable and mask on a qualified write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            mask_o <= '0;
        end else if (wr_i) begin
            en_o   <= wdata_i[0];
            mask_o <= wdata_i[MASK_W:1];
        end
    end
endmodule

// File: rtl/ecc_mon_capture.sv
// Module: sticky status flag plus first-error address latch for one error class.
// Assumes ev_i is a single-cycle pulse and clr_i is a decoded write-one-to-clear.
module ecc_mon_capture #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              ev_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic              clr_i,
    output logic              status_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic hit;
    assign hit = en_i & ev_i;

    // Status: a set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     status_o <= 1'b0;
        else if (hit)   status_o <= 1'b1;
        else if (clr_i) status_o <= 1'b0;
    end

    // Address: captured only when the flag was clear before this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                addr_o <= '0;
        else if (hit && !status_o) addr_o <= ev_addr_i;
    end

    // R4 / R5: a set flag freezes the captured address
    p_addr_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o |=> $stable(addr_o));
    // R6 / R8: an enabled error always leaves the flag set
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ev_i) |=> status_o);
    // R5 / R4: the first error's address is the one captured
    p_first_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ev_i && !status_o) |=> (addr_o == $past(ev_addr_i)));
    // R9: a disabled block does not raise a clear flag
    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !status_o) |=> !status_o);
endmodule

// File: rtl/ecc_err_monitor.sv
// Module: top of the ECC error monitor; decodes the register window,
// instantiates the control register and one capture unit per error class.
// Assumes single-cycle writes and a combinational read path.
module ecc_err_monitor #(
    parameter int REG_AW = 5,
    parameter int ERR_AW = 15,
    parameter int MASK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_single,
    input  logic              ev_double,
    input  logic [ERR_AW-1:0] ev_addr,
    output logic              ecc_en,
    output logic [MASK_W-1:0] syn_flip,
    output logic              irq
);
    import ecc_mon_pkg::*;

    localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
    localparam logic [REG_AW-1:0] A_SADR = REG_AW'(OFS_SBE_ADDR);
    localparam logic [REG_AW-1:0] A_DADR = REG_AW'(OFS_DBE_ADDR);
    localparam logic [REG_AW-1:0] A_SST  = REG_AW'(OFS_SBE_STAT);
    localparam logic [REG_AW-1:0] A_DST  = REG_AW'(OFS_DBE_STAT);

    logic [NUM_CLASSES-1:0] ev_vec, clr_vec, st_vec;
    logic [ERR_AW-1:0]      addr_arr [NUM_CLASSES];
    logic                   unused_wdata;

    assign unused_wdata = ^reg_wdata[31:MASK_W+1];
    assign ev_vec  = {ev_double, ev_single};
    assign clr_vec = {reg_wr && reg_addr == A_DST && reg_wdata[0],
                      reg_wr && reg_addr == A_SST && reg_wdata[0]};

    ecc_mon_ctrl_reg #(.MASK_W(MASK_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr && reg_addr == A_CTRL),
        .wdata_i (reg_wdata[MASK_W:0]),
        .en_o    (ecc_en),
        .mask_o  (syn_flip)
    );

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
        ecc_mon_capture #(.ADDR_W(ERR_AW)) u_cap (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (ecc_en),
            .ev_i      (ev_vec[c]),
            .ev_addr_i (ev_addr),
            .clr_i     (clr_vec[c]),
            .status_o  (st_vec[c]),
            .addr_o    (addr_arr[c])
        );
    end

    assign irq = |st_vec;

    // Read mux: mapped offsets return their fields, all else reads zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata = {{(31-MASK_W){1'b0}}, syn_flip, ecc_en};
            A_SADR: reg_rdata = {{(32-ERR_AW){1'b0}}, addr_arr[0]};
            A_DADR: reg_rdata = {{(32-ERR_AW){1'b0}}, addr_arr[1]};
            A_SST:  reg_rdata = {31'b0, st_vec[0]};
            A_DST:  reg_rdata = {31'b0, st_vec[1]};
            default: reg_rdata = '0;
        endcase
    end

    // R7: an interrupt only rises after an enabled error pulse
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ecc_en && (ev_single || ev_double)));
endmodule

// File: tb/ecc_err_monitor_test.sv
`timescale 1ns/100ps
module ecc_err_monitor_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  reg_addr;
    logic        reg_wr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        ev_single, ev_double;
    logic [14:0] ev_addr;
    logic        ecc_en, irq;
    logic [7:0]  syn_flip;

    int errors = 0;
    int checks = 0;

    // reference model state
    logic       m_en;
    logic [7:0] m_mask;
    logic       m_sst, m_dst;
    logic [14:0] m_sa, m_da;

    always #2.5 clk = ~clk;   // 200 MHz

    ecc_err_monitor uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_single(ev_single),
        .ev_double(ev_double), .ev_addr(ev_addr), .ecc_en(ecc_en),
        .syn_flip(syn_flip), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00: return {23'b0, m_mask, m_en};
            5'h04: return {17'b0, m_sa};
            5'h08: return {17'b0, m_da};
            5'h0C: return {31'b0, m_sst};
            5'h10: return {31'b0, m_dst};
            default: return 32'h0;
        endcase
    endfunction

    // model update for one clock edge, using pre-edge state
    task automatic model_edge(input logic wr, input logic [4:0] a, input logic [31:0] wd,
                              input logic s, input logic d, input logic [14:0] ea);
        logic hs, hd, cs, cd;
        hs = m_en & s;
        hd = m_en & d;
        cs = wr && a == 5'h0C && wd[0];
        cd = wr && a == 5'h10 && wd[0];
        if (hs && !m_sst) m_sa = ea;
        if (hd && !m_dst) m_da = ea;
        m_sst = hs ? 1'b1 : (cs ? 1'b0 : m_sst);
        m_dst = hd ? 1'b1 : (cd ? 1'b0 : m_dst);
        if (wr && a == 5'h00) begin
            m_en   = wd[0];
            m_mask = wd[8:1];
        end
    endtask

    // called in the low phase: drive, clock, return at next falling edge
    task automatic step(input logic wr, input logic [4:0] a, input logic [31:0] wd,
                        input logic s, input logic d, input logic [14:0] ea);
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        ev_single = s; ev_double = d; ev_addr = ea;
        @(posedge clk);
        model_edge(wr, a, wd, s, d, ea);
        @(negedge clk);
        reg_wr = 1'b0; ev_single = 1'b0; ev_double = 1'b0;
    endtask

    // read every register and compare outputs, all inside the low phase
    task automatic check_regs(input string tag);
        reg_wr = 1'b0; ev_single = 1'b0; ev_double = 1'b0;
        foreach (tag[i]) ;
        for (int i = 0; i < 6; i++) begin
            logic [4:0] a;
            a = (i == 5) ? 5'h14 : 5'(i * 4);
            reg_addr = a;
            #0.2;
            chk($sformatf("%s R1 read off %h", tag, a), reg_rdata, exp_read(a));
        end
        chk({tag, " R2 ecc_en"},   {31'b0, ecc_en},   {31'b0, m_en});
        chk({tag, " R2 syn_flip"}, {24'b0, syn_flip}, {24'b0, m_mask});
        chk({tag, " R7 irq"},      {31'b0, irq},      {31'b0, m_sst | m_dst});
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd7);
        m_en = 0; m_mask = 0; m_sst = 0; m_dst = 0; m_sa = 0; m_da = 0;
        rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        ev_single = 0; ev_double = 0; ev_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_regs("R11 reset");

        // R9: disabled block ignores errors
        step(0, 0, 0, 1, 1, 15'h1234);
        check_regs("R9 disabled");

        // R2: enable with a mask, upper write bits dropped
        step(1, 5'h00, 32'hFFFF_FE55, 0, 0, 0);
        check_regs("R2 ctrl");

        // R4: first SBE captured, second one held
        step(0, 0, 0, 1, 0, 15'h0ABC);
        step(0, 0, 0, 1, 0, 15'h7FFF);
        check_regs("R4 sbe hold");

        // R6: writing 0 does not clear
        step(1, 5'h0C, 32'hFFFF_FFFE, 0, 0, 0);
        check_regs("R6 wr0");

        // R3: writes to address registers ignored
        step(1, 5'h04, 32'hFFFF_FFFF, 0, 0, 0);
        step(1, 5'h08, 32'hFFFF_FFFF, 0, 0, 0);
        check_regs("R3 ro");

        // R1: unmapped write ignored
        step(1, 5'h14, 32'hFFFF_FFFF, 0, 0, 0);
        step(1, 5'h02, 32'hFFFF_FFFF, 0, 0, 0);
        check_regs("R1 unmapped");

        // R8: set and clear same cycle, bit already set -> no new capture
        step(1, 5'h0C, 32'h1, 1, 0, 15'h1111);
        check_regs("R8 set wins");

        // R6: clear with 1
        step(1, 5'h0C, 32'h1, 0, 0, 0);
        check_regs("R6 clear");

        // R10: both classes in one cycle
        step(0, 0, 0, 1, 1, 15'h2222);
        check_regs("R10 both");

        // R5: DBE held, then cleared and recaptured
        step(0, 0, 0, 0, 1, 15'h3333);
        check_regs("R5 dbe hold");
        step(1, 5'h10, 32'h1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 15'h4444);
        check_regs("R5 dbe recapture");

        // random phase
        for (int n = 0; n < 400; n++) begin
            logic [4:0] a;
            logic [31:0] wd;
            case ($urandom_range(0, 6))
                0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08;
                3, 4: a = 5'h0C; 5: a = 5'h10;
                default: a = 5'($urandom);
            endcase
            wd = $urandom;
            if (a == 5'h00 && $urandom_range(0, 3) != 0) wd[0] = 1'b1;
            step(1'($urandom_range(0, 2) == 0), a, wd,
                 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) == 0),
                 15'($urandom));
            if (n % 4 == 0) check_regs("R8 R10 random");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule